// File: doc/BRIEF.md
# Pulsed Overload Protection Sequencer

This block decides whether a supply regulator's output may be on. It watches an asynchronous overload-detect line from the analog current clamp, a pair of temperature comparator flags (a hot trip and a lower cool release), a power-enable bit and a mode bit. From these it drives one output-enable line and two status flags, one for overload and one for over-temperature.

In pulsed mode, an overload switches the output off for a long rest interval. The output then comes back for a probe interval that is one tenth as long. If the overload is seen at any point during the probe, the off/on cycle starts again. A probe with no overload returns the block to normal running. In static mode the output is never switched off because of overload, and the overload flag only mirrors the clamp condition. Thermal shutdown latches on the hot trip and releases only on the cool indication. Both intervals are parameters counted in clock cycles.

Top module: `ovl_pulse_guard`

## Requirements
- R1: After reset the block is in normal running with `ovl_flag` and `hot_flag` low, so `out_en` equals `pwr_en`.
- R2: In pulsed mode (`static_mode` = 0), `ovl_raw` is synchronised through SYNC_STAGES flops. An overload driven on `ovl_raw` drops `out_en` and raises `ovl_flag` on the same clock edge, SYNC_STAGES+1 edges after it is first sampled.
- R3: The rest interval lasts exactly OFF_TICKS cycles. The probe interval that follows lasts exactly OFF_TICKS/ON_RATIO cycles.
- R4: A synchronised overload seen in any cycle of the probe interval, including its last cycle, sends the block back to rest on the edge that ends the probe.
- R5: A probe interval with no overload returns the block to normal running. `ovl_flag` falls on the edge that ends the probe, and `out_en` stays high.
- R6: In static mode (`static_mode` = 1), overload never lowers `out_en`. `ovl_flag` follows the synchronised overload with one extra register, so it rises and falls SYNC_STAGES+1 edges after `ovl_raw` does.
- R7: Raising `static_mode` during rest aborts the cycle, and `out_en` returns on the next edge.
- R8: `temp_hot` sets `hot_flag` and lowers `out_en` on the next edge. `hot_flag` then holds until an edge where `temp_cool` is high and `temp_hot` is low. When both are high, `temp_hot` wins.
- R9: While `pwr_en` is low, `out_en` is low, whatever the protection state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovl_raw | input | 1 | Overload detect from current clamp, asynchronous |
| temp_hot | input | 1 | Over-temperature trip comparator |
| temp_cool | input | 1 | Temperature release comparator |
| pwr_en | input | 1 | Power enable |
| static_mode | input | 1 | 1 = static clamp reporting, 0 = pulsed retry |
| out_en | output | 1 | Regulator output enable |
| ovl_flag | output | 1 | Overload status |
| hot_flag | output | 1 | Over-temperature status |

## Verification
The bench sweeps the cycle at which a one-cycle overload pulse arrives, relative to the start of a probe window. Each position predicts either an immediate return to rest when the probe ends, or a later fresh trip from normal running. A design that ignored an overload seen only early in the probe, or that sampled only in the last cycle, would re-enable early or late at the probe boundary. The rest and probe lengths are measured as runs of `out_en` low and high; an off-by-one counter load shows up as one extra or one missing cycle. Other checks cover a mode switch during rest, a hot/cool overlap where both comparators are high, and a flag that clears one edge late after a clean probe.

// File: rtl/ovl_pulse_guard.sv
module ovl_pulse_guard #(
  parameter int OFF_TICKS   = 900000,
  parameter int ON_RATIO    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovl_raw,
  input  logic temp_hot,
  input  logic temp_cool,
  input  logic pwr_en,
  input  logic static_mode,
  output logic out_en,
  output logic ovl_flag,
  output logic hot_flag
);
  localparam int ON_TICKS = (OFF_TICKS / ON_RATIO > 0) ? OFF_TICKS / ON_RATIO : 1;
  localparam int CW       = $clog2(OFF_TICKS + 1);

  typedef enum logic [1:0] {RUN, REST, PROBE} phase_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ovl_s;
  phase_t                 phase_q, phase_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   hit_q, hit_d;

  assign ovl_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= ovl_raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    hit_d   = hit_q;
    if (static_mode) begin
      phase_d = RUN;
      cnt_d   = '0;
      hit_d   = 1'b0;
    end else begin
      case (phase_q)
        RUN: if (ovl_s) begin
          phase_d = REST;
          cnt_d   = CW'(OFF_TICKS - 1);
        end
        REST: if (cnt_q == '0) begin
          phase_d = PROBE;
          cnt_d   = CW'(ON_TICKS - 1);
          hit_d   = 1'b0;
        end else cnt_d = cnt_q - CW'(1);
        PROBE: begin
          hit_d = hit_q | ovl_s;
          if (cnt_q == '0) begin
            hit_d = 1'b0;
            if (hit_q | ovl_s) begin
              phase_d = REST;
              cnt_d   = CW'(OFF_TICKS - 1);
            end else phase_d = RUN;
          end else cnt_d = cnt_q - CW'(1);
        end
        default: phase_d = RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= RUN;
      cnt_q    <= '0;
      hit_q    <= 1'b0;
      ovl_flag <= 1'b0;
      hot_flag <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      hit_q    <= hit_d;
      ovl_flag <= static_mode ? ovl_s : (phase_d != RUN);
      hot_flag <= temp_hot ? 1'b1 : (temp_cool ? 1'b0 : hot_flag);
    end
  end

  assign out_en = pwr_en & ~hot_flag & (phase_q != REST);
endmodule

module ovl_pulse_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic temp_hot,
  input logic temp_cool,
  input logic pwr_en,
  input logic static_mode,
  input logic out_en,
  input logic ovl_flag,
  input logic hot_flag
);
  assert_pwr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> !out_en);

  assert_hot_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    temp_hot |=> (hot_flag && !out_en));

  assert_hot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_flag && !temp_cool) |=> hot_flag);

  assert_static_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    static_mode |=> (out_en || !pwr_en || hot_flag));

  assert_off_flagged_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!static_mode && pwr_en && !hot_flag && !out_en) |-> ovl_flag);
endmodule

bind ovl_pulse_guard ovl_pulse_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .temp_hot(temp_hot), .temp_cool(temp_cool),
  .pwr_en(pwr_en), .static_mode(static_mode), .out_en(out_en),
  .ovl_flag(ovl_flag), .hot_flag(hot_flag)
);

// File: tb/ovl_pulse_guard_test.sv
module ovl_pulse_guard_test;
  localparam int OFF  = 40;
  localparam int RAT  = 10;
  localparam int SYN  = 2;
  localparam int ON   = OFF / RAT;
  localparam int LAT  = SYN + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ovl_raw = 1'b0, temp_hot = 1'b0, temp_cool = 1'b0;
  logic pwr_en = 1'b1, static_mode = 1'b0;
  logic out_en, ovl_flag, hot_flag;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  ovl_pulse_guard #(.OFF_TICKS(OFF), .ON_RATIO(RAT), .SYNC_STAGES(SYN)) uut (
    .clk(clk), .rst_n(rst_n), .ovl_raw(ovl_raw), .temp_hot(temp_hot),
    .temp_cool(temp_cool), .pwr_en(pwr_en), .static_mode(static_mode),
    .out_en(out_en), .ovl_flag(ovl_flag), .hot_flag(hot_flag));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic wait_low();
    while (out_en) tick();
  endtask

  task automatic wait_high();
    while (!out_en) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n;
    int drop;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 out_en after reset", out_en, 1);
    chk("R1 ovl_flag after reset", ovl_flag, 0);
    chk("R1 hot_flag after reset", hot_flag, 0);

    // R6 static mode mirrors the clamp
    static_mode = 1'b1;
    ovl_raw = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      tick();
      chk("R6 static flag rise", ovl_flag, (k >= LAT) ? 1 : 0);
      chk("R6 static out_en", out_en, 1);
    end
    ovl_raw = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      tick();
      chk("R6 static flag fall", ovl_flag, (k >= LAT) ? 0 : 1);
    end
    static_mode = 1'b0;
    tick();

    // R2 trip latency, R3 interval lengths, R4 persistent overload retries
    ovl_raw = 1'b1;
    for (int k = 1; k <= LAT; k++) begin
      tick();
      chk("R2 out_en trip", out_en, (k < LAT) ? 1 : 0);
      chk("R2 ovl_flag trip", ovl_flag, (k < LAT) ? 0 : 1);
    end
    n = 0;
    while (!out_en && n < 1000) begin n++; tick(); end
    chk("R3 rest length", n, OFF);
    n = 0;
    while (out_en && n < 1000) begin n++; tick(); end
    chk("R4 probe length then retry", n, ON);
    ovl_raw = 1'b0;
    n = 0;
    while (!out_en && n < 1000) begin n++; tick(); end
    chk("R3 second rest length", n, OFF);
    chk("R5 flag held in probe", ovl_flag, 1);
    repeat (ON - 1) tick();
    chk("R5 flag before probe end", ovl_flag, 1);
    tick();
    chk("R5 flag cleared at probe end", ovl_flag, 0);
    chk("R5 out_en after clean probe", out_en, 1);
    repeat (5) tick();
    chk("R5 stays running", out_en, 1);

    // R4 sweep of pulse position relative to probe start
    for (int d = 0; d <= ON + 2; d++) begin
      ovl_raw = 1'b1; tick(); ovl_raw = 1'b0;
      wait_low();
      wait_high();
      drop = -1;
      for (int j = 0; j < ON + d + 8; j++) begin
        ovl_raw = (j == d);
        tick();
        if (!out_en && drop < 0) drop = j + 1;
      end
      ovl_raw = 1'b0;
      chk("R4 retry point for pulse offset", drop, (d <= ON - 3) ? ON : d + LAT);
      wait_high();
      repeat (ON + 3) tick();
      chk("R5 flag clear after sweep step", ovl_flag, 0);
    end

    // R7 static switch aborts rest
    ovl_raw = 1'b1; tick(); ovl_raw = 1'b0;
    wait_low();
    repeat (5) tick();
    static_mode = 1'b1;
    tick();
    chk("R7 abort restores out_en", out_en, 1);
    static_mode = 1'b0;
    repeat (OFF + 4) tick();
    chk("R7 stays running after abort", out_en, 1);
    chk("R7 flag clear after abort", ovl_flag, 0);

    // R8 thermal hysteresis
    temp_hot = 1'b1; tick();
    chk("R8 hot set", hot_flag, 1);
    chk("R8 hot out_en", out_en, 0);
    temp_hot = 1'b0; repeat (3) tick();
    chk("R8 hot held without cool", hot_flag, 1);
    chk("R8 out_en held off", out_en, 0);
    temp_cool = 1'b1; tick();
    chk("R8 cool release", hot_flag, 0);
    chk("R8 out_en after release", out_en, 1);
    temp_hot = 1'b1; tick();
    chk("R8 hot wins over cool", hot_flag, 1);
    temp_hot = 1'b0; tick();
    chk("R8 release with cool only", hot_flag, 0);
    temp_cool = 1'b0; tick();

    // R9 power gate
    pwr_en = 1'b0; tick();
    chk("R9 out_en with power off", out_en, 0);
    static_mode = 1'b1; tick();
    chk("R9 out_en off in static", out_en, 0);
    static_mode = 1'b0;
    pwr_en = 1'b1; tick();
    chk("R9 out_en restored", out_en, 1);

    finish_run();
  end
endmodule